// File: doc/BRIEF.md
# Dual-Mode PWM Timer Channel

This block is a 16-bit timer with a single PWM output. Software programs it through an 8-bit write port. The settings are a period limit (the modulus), a 16-bit compare value, a counting-mode bit and a polarity bit. In edge mode the counter only counts up and then reloads. In center mode it counts up to the modulus and back down to zero, which gives a symmetric pulse centred on the zero point.

The compare value is written one byte at a time. The bytes collect in a staging buffer. The active compare register takes the new value only after both bytes have arrived and the counter reaches its reload point. A duty change therefore never produces a partial or torn pulse. The modulus and control bits take effect as soon as they are written.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset the output is low, the block is in edge mode with polarity 0, and the counter, modulus, compare value and staging buffer are all zero. The output therefore stays low until a compare value is loaded.
- R2: In edge mode (control bit 0 = 0) with a nonzero modulus M, the counter steps 0..M and wraps to 0, so the period is M+1 clocks. With polarity 0, the output goes high one clock after the counter is 0 and goes low one clock after the counter equals the compare value V. The output is therefore high for V clocks of each period.
- R3: Control bit 1 (polarity) inverts the output level in both modes.
- R4: In edge mode, V = 0 gives constant inactive output (0% duty). V > M gives constant active output (100% duty).
- R5: In center mode (control bit 0 = 1) with a modulus M from 1 to 0x7FFF, the counter runs 0 up to M and then down to 0, so the period is 2*M clocks. A match while counting up drives the output inactive, and a match while counting down drives it active, so the active pulse lasts 2*V clocks for 0 < V < M.
- R6: In center mode, V = 0 or V with bit 15 set gives 0% duty. A V with bit 15 clear and greater than M gives 100% duty.
- R7: Writes to the compare value low byte or high byte go to a staging buffer, in either order. The active compare value changes only after both bytes have been staged. The flag for each staged byte clears when the transfer happens.
- R8: The staged value transfers only at the reload point: when the counter is 0 in edge mode, or when it turns from up to down at M in center mode.
- R9: Write address map: 0 = control (bit 0 mode, bit 1 polarity), 1 = modulus low byte, 2 = modulus high byte, 3 = compare low byte, 4 = compare high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_addr | input | 3 | Target register address |
| wr_data | input | 8 | Byte to write |
| pwm_out | output | 1 | PWM output pin |

## Verification
The assertions assume that a center-mode modulus is nonzero and below 0x8000. They also assume that the modulus is not moved below the running count in edge mode, because that would make the counter run through its full 16-bit range. The bench pulses reset before every vector and writes the modulus within a few clocks of reset, while the count is still small. Every modulus it uses is at least 9, and its center-mode values stay far below 0x8000. Duty is measured over whole periods only after enough periods have passed for the staged compare value to be loaded.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_MOD_LO = 3'd1,
    ADDR_MOD_HI = 3'd2,
    ADDR_VAL_LO = 3'd3,
    ADDR_VAL_HI = 3'd4
  } addr_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              load,
  output logic              mode,
  output logic              pol,
  output logic [CNT_W-1:0]  mod_val,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              pend_lo,
  output logic              pend_hi
);
  logic              mode_d, pol_d, plo_d, phi_d;
  logic [CNT_W-1:0]  mod_d, cmp_d, stg_q, stg_d;

  always_comb begin
    mode_d = mode;
    pol_d  = pol;
    mod_d  = mod_val;
    stg_d  = stg_q;
    cmp_d  = load ? stg_q : cmp_val;
    plo_d  = load ? 1'b0 : pend_lo;
    phi_d  = load ? 1'b0 : pend_hi;
    if (wr_en) begin
      case (addr_e'(wr_addr))
        ADDR_CTRL:   begin mode_d = wr_data[0]; pol_d = wr_data[1]; end
        ADDR_MOD_LO: mod_d[BYTE_W-1:0]     = wr_data;
        ADDR_MOD_HI: mod_d[CNT_W-1:BYTE_W] = wr_data;
        ADDR_VAL_LO: begin stg_d[BYTE_W-1:0]     = wr_data; plo_d = 1'b1; end
        ADDR_VAL_HI: begin stg_d[CNT_W-1:BYTE_W] = wr_data; phi_d = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= 1'b0;
      pol     <= 1'b0;
      mod_val <= '0;
      stg_q   <= '0;
      cmp_val <= '0;
      pend_lo <= 1'b0;
      pend_hi <= 1'b0;
    end else begin
      mode    <= mode_d;
      pol     <= pol_d;
      mod_val <= mod_d;
      stg_q   <= stg_d;
      cmp_val <= cmp_d;
      pend_lo <= plo_d;
      pend_hi <= phi_d;
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_up,
  output logic             reload
);
  logic [CNT_W-1:0] cnt_d;
  logic             up_d;
  logic             at_mod, at_zero;

  assign at_mod  = (cnt == mod_val);
  assign at_zero = (cnt == '0);
  assign reload  = mode ? (cnt_up && at_mod) : at_zero;

  always_comb begin
    cnt_d = cnt + CNT_W'(1);
    up_d  = 1'b1;
    if (!mode) begin
      if (at_mod && (mod_val != '0)) cnt_d = '0;
    end else if (cnt_up) begin
      if (at_mod) begin
        up_d  = 1'b0;
        cnt_d = cnt - CNT_W'(1);
      end
    end else begin
      if (at_zero) begin
        up_d = 1'b1;
      end else begin
        up_d  = 1'b0;
        cnt_d = cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      cnt_up <= 1'b1;
    end else begin
      cnt    <= cnt_d;
      cnt_up <= up_d;
    end
  end
endmodule

// File: rtl/pwm_outlogic.sv
module pwm_outlogic
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_up,
  input  logic [CNT_W-1:0] mod_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             pwm_out
);
  logic level_q, level_d;
  logic hit;

  assign hit = (cnt == cmp_val);

  always_comb begin
    level_d = level_q;
    if (!mode) begin
      if (hit)               level_d = 1'b0;
      else if (cnt == '0)    level_d = 1'b1;
    end else begin
      if ((cmp_val == '0) || cmp_val[CNT_W-1]) level_d = 1'b0;
      else if (cmp_val > mod_val)              level_d = 1'b1;
      else if (hit)                            level_d = !cnt_up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign pwm_out = level_q ^ pol;
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              pwm_out
);
  logic             rst_m, rst_s;
  logic             mode, pol, pend_lo, pend_hi, cnt_up, reload, load;
  logic [CNT_W-1:0] mod_val, cmp_val, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign load = reload && pend_lo && pend_hi;

  pwm_regs u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .mode(mode), .pol(pol),
    .mod_val(mod_val), .cmp_val(cmp_val), .pend_lo(pend_lo), .pend_hi(pend_hi)
  );

  pwm_counter u_cnt (
    .clk(clk), .rst_n(rst_s), .mode(mode), .mod_val(mod_val),
    .cnt(cnt), .cnt_up(cnt_up), .reload(reload)
  );

  pwm_outlogic u_out (
    .clk(clk), .rst_n(rst_s), .mode(mode), .pol(pol), .cnt(cnt),
    .cnt_up(cnt_up), .mod_val(mod_val), .cmp_val(cmp_val), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              mode,
  input logic              pol,
  input logic [CNT_W-1:0]  mod_val,
  input logic [CNT_W-1:0]  cmp_val,
  input logic [CNT_W-1:0]  cnt,
  input logic              cnt_up,
  input logic              pend_lo,
  input logic              pend_hi,
  input logic              pwm_out
);
  assert_edge_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && mod_val != '0 && cnt == mod_val) |=> (cnt == '0));

  assert_center_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && cnt_up && mod_val != '0 && cnt == mod_val) |=> !cnt_up);

  assert_neg_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode && cmp_val[CNT_W-1]) |-> (pwm_out == pol));

  assert_stage_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_VAL_LO) |=> pend_lo);

  assert_load_point_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val != $past(cmp_val)) |->
      $past(pend_lo && pend_hi && (mode ? (cnt_up && cnt == mod_val) : (cnt == '0))));
endmodule

bind pwm_timer_chan pwm_timer_chk u_chk (
  .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr), .mode(mode),
  .pol(pol), .mod_val(mod_val), .cmp_val(cmp_val), .cnt(cnt), .cnt_up(cnt_up),
  .pend_lo(pend_lo), .pend_hi(pend_hi), .pwm_out(pwm_out)
);

// File: tb/pwm_timer_chan_test.sv
module pwm_timer_chan_test;
  logic       clk, rst_n, wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       pwm_out;
  int total = 0, bad = 0;

  pwm_timer_chan uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                      .wr_data(wr_data), .pwm_out(pwm_out));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {mode, pol, modulus, value, period, ones over two periods}
  localparam int NV = 9;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'd9,  16'd4,      8'd10, 8'd8 },  // R2
    {1'b0, 1'b1, 16'd9,  16'd4,      8'd10, 8'd12},  // R3
    {1'b0, 1'b0, 16'd9,  16'd0,      8'd10, 8'd0 },  // R4
    {1'b0, 1'b0, 16'd9,  16'd12,     8'd10, 8'd20},  // R4
    {1'b0, 1'b0, 16'd9,  16'd9,      8'd10, 8'd18},  // R2
    {1'b1, 1'b0, 16'd10, 16'd3,      8'd20, 8'd12},  // R5
    {1'b1, 1'b1, 16'd10, 16'd3,      8'd20, 8'd28},  // R3
    {1'b1, 1'b0, 16'd10, 16'h8003,   8'd20, 8'd0 },  // R6
    {1'b1, 1'b0, 16'd10, 16'd11,     8'd20, 8'd40}   // R6
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ones(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) c++;
    end
  endtask

  task automatic rise_gap(output int g);
    logic prev;
    g = 0;
    prev = pwm_out;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
    prev = pwm_out;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      g++;
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
  endtask

  task automatic setup(input logic m, input logic p, input logic [15:0] mv,
                       input logic [15:0] v);
    do_reset();
    wr(3'd1, mv[7:0]);
    wr(3'd2, mv[15:8]);
    wr(3'd0, {6'd0, p, m});
    wr(3'd3, v[7:0]);
    wr(3'd4, v[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, g;
    // R1: reset state, output low with zero compare value
    do_reset();
    check("R1 reset output", int'(pwm_out), 0);
    ones(40, c);
    check("R1 idle after reset", c, 0);

    // Table walk, R9 address map used throughout
    for (int k = 0; k < NV; k++) begin
      setup(VEC[k][49], VEC[k][48], VEC[k][47:32], VEC[k][31:16]);
      repeat (4 * int'(VEC[k][15:8])) @(negedge clk);
      ones(2 * int'(VEC[k][15:8]), c);
      check($sformatf("R2-table vector %0d (R9)", k), c, int'(VEC[k][7:0]));
    end

    // R2 period in edge mode
    setup(1'b0, 1'b0, 16'd9, 16'd4);
    repeat (20) @(negedge clk);
    rise_gap(g);
    check("R2 edge period", g, 10);

    // R5 period in center mode
    setup(1'b1, 1'b0, 16'd10, 16'd3);
    repeat (40) @(negedge clk);
    rise_gap(g);
    check("R5 center period", g, 20);

    // R7 staging: low byte alone must not change duty
    setup(1'b0, 1'b0, 16'd9, 16'd4);
    repeat (30) @(negedge clk);
    wr(3'd3, 8'd7);
    repeat (40) @(negedge clk);
    ones(20, c);
    check("R7 partial write ignored", c, 8);
    wr(3'd4, 8'd0);
    repeat (40) @(negedge clk);
    ones(20, c);
    check("R7 both bytes applied", c, 14);
    // R7 reverse byte order, R8 load at reload point
    wr(3'd4, 8'd0);
    repeat (25) @(negedge clk);
    ones(20, c);
    check("R7 high byte alone ignored", c, 14);
    wr(3'd3, 8'd2);
    repeat (40) @(negedge clk);
    ones(20, c);
    check("R8 reverse order applied", c, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule